// File: doc/BRIEF.md
# Watchdog Timer with Keyed Start and Stop

This block is a memory-mapped watchdog timer split across two clocks. Software reaches it through a small register port on a fast bus clock. The timing engine runs on a separate slow functional clock. Its main part is an up-counter that feeds a reset generator, with an optional power-of-two prescaler in front of the counter. The counter runs only after software writes two keyed words to the sequence register in the right order. A different pair of keyed words halts it. Software keeps the system alive by writing a trigger value that differs from the previous one. Each such write reloads the counter from the load register.

Writes to the control, load, trigger and sequence registers are posted. Each one shows a pending flag until the functional-clock side has taken the value. While that flag is set, another write to the same register is dropped. When the counter passes its all-ones value while running, the block drives its reset output for a fixed number of functional clocks. The counter then continues from the load value. The revision and system-configuration registers stay on the bus side and respond at once.

Top module: `wdt_unlock`

## Requirements
- R1: After reset the counter is stopped and reads 0, the load register reads 0, the pending register reads 0 and `wdt_reset` is low.
- R2: Writing 16'hBBBB and then 16'h4444 to the sequence register (word address 7) starts the counter, and it advances upward.
- R3: Any other ordering leaves the counter stopped and its value unchanged. This includes 4444 before BBBB and another word between the two keys.
- R4: Writing 16'hAAAA and then 16'h5555 to the sequence register stops the counter, and its value then holds.
- R5: The pending register (word address 6) has bit 0 for control (address 2), bit 2 for load (address 4), bit 3 for trigger (address 5) and bit 4 for sequence. A bit is set on the bus cycle after an accepted write and clears once the functional-clock side has taken the value.
- R6: A write to a posted register while its pending bit is set is ignored. The register keeps the earlier value on both clock sides.
- R7: A trigger write whose value differs from the previous trigger value reloads the counter from the load register. A trigger write with the same value leaves the counter unchanged.
- R8: In the control register, bit 5 enables the prescaler and bits 4:2 hold the exponent P. With the prescaler on, the counter advances once per 2^P functional clocks. With it off, the counter advances on every functional clock. The control register reads back only bits 5:2.
- R9: When the running counter advances past 32'hFFFFFFFF, `wdt_reset` goes high for RST_CYCLES functional clocks and the counter continues from the load value. Rising edges of `wdt_reset` are therefore (2^32 - load) * 2^P functional clocks apart.
- R10: The revision register (address 0) reads REV_CODE in bits 7:0 and ignores writes. The system-configuration register (address 1) holds a read/write bit 0, and all its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Register bus clock |
| fclk | input | 1 | Slow functional clock for the counter |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_reset | output | 1 | Watchdog reset pulse, functional-clock domain |

## Verification
The bench targets the key orderings: reversed keys, and a stray word placed between the two start keys. A design that starts on any key it sees would let the counter move in these cases. It writes the same trigger value twice: a design that reloads on every trigger write would reset the counter when it should hold. It also writes a register a second time while the first write is still pending. A design that does not gate on the pending flag would read back the second value, or would hand a half-changed value to the counter. Finally, the bench measures the exact spacing and width of the reset pulses in functional clocks, with and without the prescaler. An off-by-one error in the prescaler limit or in the wrap test would change those numbers.

// File: rtl/wdu_pkg.sv
package wdu_pkg;

   localparam int ADDR_W = 3;
   localparam int BUS_W  = 32;
   localparam int KEY_W  = 16;

   typedef enum logic [ADDR_W-1:0] {
      RA_REV   = 3'd0,
      RA_SYS   = 3'd1,
      RA_CTRL  = 3'd2,
      RA_COUNT = 3'd3,
      RA_LOAD  = 3'd4,
      RA_TRIG  = 3'd5,
      RA_PEND  = 3'd6,
      RA_SEQ   = 3'd7
   } reg_addr_e;

   // pending register bit positions
   localparam int PB_CTRL = 0;
   localparam int PB_LOAD = 2;
   localparam int PB_TRIG = 3;
   localparam int PB_SEQ  = 4;

   // control register field positions
   localparam int CB_PEN   = 5;
   localparam int CB_PTV_L = 2;
   localparam int PTV_W    = 3;
   localparam int CTRL_W   = PTV_W + 1;

   localparam logic [KEY_W-1:0] KEY_RUN_A  = 16'hBBBB;
   localparam logic [KEY_W-1:0] KEY_RUN_B  = 16'h4444;
   localparam logic [KEY_W-1:0] KEY_HALT_A = 16'hAAAA;
   localparam logic [KEY_W-1:0] KEY_HALT_B = 16'h5555;

endpackage

// File: rtl/wdu_posted_reg.sv
// One posted register: bus-side copy, toggle handshake to the functional
// clock, pending flag held until the far side acknowledges.
module wdu_posted_reg #(
   parameter int W = 8
) (
   input  logic         bclk,
   input  logic         fclk,
   input  logic         rst_n,
   input  logic         wr_hit,
   input  logic [W-1:0] wdata,
   output logic         busy,
   output logic [W-1:0] shadow,
   output logic         f_stb
);
   logic req_t, ack_s1, ack_s2;
   logic req_f1, req_f2, ack_f;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
         req_t  <= 1'b0;
         ack_s1 <= 1'b0;
         ack_s2 <= 1'b0;
      end else begin
         ack_s1 <= ack_f;
         ack_s2 <= ack_s1;
         if (wr_hit && !busy) begin
            shadow <= wdata;
            req_t  <= ~req_t;
         end
      end
   end

   assign busy = req_t ^ ack_s2;

   always_ff @(posedge fclk or negedge rst_n) begin
      if (!rst_n) begin
         req_f1 <= 1'b0;
         req_f2 <= 1'b0;
         ack_f  <= 1'b0;
      end else begin
         req_f1 <= req_t;
         req_f2 <= req_f1;
         ack_f  <= req_f2;
      end
   end

   // shadow is frozen while busy, so the far side may sample it here
   assign f_stb = req_f2 ^ ack_f;

   assert_busy_hold_R6: assert property (@(posedge bclk) disable iff (!rst_n)
      (busy && wr_hit) |=> $stable(shadow));

   assert_pend_set_R5: assert property (@(posedge bclk) disable iff (!rst_n)
      (wr_hit && !busy) |=> busy);

endmodule

// File: rtl/wdu_snap.sv
// Continuous request/acknowledge snapshot of the counter into the bus clock.
module wdu_snap #(
   parameter int W = 32
) (
   input  logic         bclk,
   input  logic         fclk,
   input  logic         rst_n,
   input  logic [W-1:0] f_val,
   output logic [W-1:0] b_val
);
   logic         sreq, a_s1, a_s2;
   logic         r_s1, r_s2, sack;
   logic [W-1:0] hold;

   always_ff @(posedge fclk or negedge rst_n) begin
      if (!rst_n) begin
         r_s1 <= 1'b0;
         r_s2 <= 1'b0;
         sack <= 1'b0;
         hold <= '0;
      end else begin
         r_s1 <= sreq;
         r_s2 <= r_s1;
         if (r_s2 != sack) begin
            hold <= f_val;
            sack <= r_s2;
         end
      end
   end

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         a_s1  <= 1'b0;
         a_s2  <= 1'b0;
         sreq  <= 1'b0;
         b_val <= '0;
      end else begin
         a_s1 <= sack;
         a_s2 <= a_s1;
         if (a_s2 == sreq) begin
            b_val <= hold;
            sreq  <= ~sreq;
         end
      end
   end

endmodule

// File: rtl/wdu_core.sv
// Functional-clock side: key sequencer, prescaler, counter, reset pulse.
module wdu_core
   import wdu_pkg::*;
#(
   parameter int CNT_W         = 32,
   parameter int RST_CYCLES    = 8,
   parameter bit HAS_PRESCALER = 1'b1
) (
   input  logic              fclk,
   input  logic              rst_n,
   input  logic              ctrl_stb,
   input  logic [CTRL_W-1:0] ctrl_val,
   input  logic              load_stb,
   input  logic [CNT_W-1:0]  load_val,
   input  logic              trig_stb,
   input  logic [CNT_W-1:0]  trig_val,
   input  logic              seq_stb,
   input  logic [KEY_W-1:0]  seq_val,
   output logic [CNT_W-1:0]  count_o,
   output logic              wdt_reset_o
);
   localparam int RC_W = $clog2(RST_CYCLES + 1);
   localparam int PS_W = (1 << PTV_W) - 1;

   logic              run;
   logic [KEY_W-1:0]  prev_word;
   logic              pen;
   logic [PTV_W-1:0]  ptv;
   logic [CNT_W-1:0]  load_q, last_trig, count;
   logic [RC_W-1:0]   rst_cnt;
   logic              tick, reload, wrap;

   // key sequencer
   always_ff @(posedge fclk or negedge rst_n) begin
      if (!rst_n) begin
         run       <= 1'b0;
         prev_word <= '0;
      end else if (seq_stb) begin
         prev_word <= seq_val;
         if (prev_word == KEY_RUN_A && seq_val == KEY_RUN_B)
            run <= 1'b1;
         else if (prev_word == KEY_HALT_A && seq_val == KEY_HALT_B)
            run <= 1'b0;
      end
   end

   // captured configuration
   always_ff @(posedge fclk or negedge rst_n) begin
      if (!rst_n) begin
         pen    <= 1'b0;
         ptv    <= '0;
         load_q <= '0;
      end else begin
         if (ctrl_stb) {pen, ptv} <= ctrl_val;
         if (load_stb) load_q <= load_val;
      end
   end

   generate
      if (HAS_PRESCALER) begin : g_presc
         logic [PS_W-1:0] pcnt;
         logic [PS_W-1:0] plimit;
         assign plimit = (PS_W'(1) << ptv) - PS_W'(1);
         always_ff @(posedge fclk or negedge rst_n) begin
            if (!rst_n)                       pcnt <= '0;
            else if (!run || !pen)            pcnt <= '0;
            else if (pcnt == plimit)          pcnt <= '0;
            else                              pcnt <= pcnt + PS_W'(1);
         end
         assign tick = run && (!pen || pcnt == plimit);
      end else begin : g_nopresc
         logic unused_cfg;
         assign unused_cfg = pen ^ (^ptv);
         assign tick = run;
      end
   endgenerate

   assign reload = trig_stb && (trig_val != last_trig);
   assign wrap   = tick && (&count) && !reload;

   always_ff @(posedge fclk or negedge rst_n) begin
      if (!rst_n) begin
         count     <= '0;
         last_trig <= '0;
      end else begin
         if (trig_stb) last_trig <= trig_val;
         if (reload)
            count <= load_q;
         else if (tick)
            count <= (&count) ? load_q : count + CNT_W'(1);
      end
   end

   always_ff @(posedge fclk or negedge rst_n) begin
      if (!rst_n)                rst_cnt <= '0;
      else if (wrap)             rst_cnt <= RC_W'(RST_CYCLES);
      else if (rst_cnt != '0)    rst_cnt <= rst_cnt - RC_W'(1);
   end

   assign wdt_reset_o = (rst_cnt != '0);
   assign count_o     = count;

   assert_start_keys_R2: assert property (@(posedge fclk) disable iff (!rst_n)
      $rose(run) |-> ($past(prev_word) == KEY_RUN_A));

   assert_stop_keys_R4: assert property (@(posedge fclk) disable iff (!rst_n)
      $fell(run) |-> ($past(prev_word) == KEY_HALT_A));

   assert_idle_hold_R3: assert property (@(posedge fclk) disable iff (!rst_n)
      (!run && !trig_stb) |=> $stable(count));

   assert_wrap_reset_R9: assert property (@(posedge fclk) disable iff (!rst_n)
      $rose(wdt_reset_o) |-> $past(&count));

endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock
   import wdu_pkg::*;
#(
   parameter int         CNT_W         = 32,
   parameter int         RST_CYCLES    = 8,
   parameter bit         HAS_PRESCALER = 1'b1,
   parameter logic [7:0] REV_CODE      = 8'h5A
) (
   input  logic              bclk,
   input  logic              fclk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              wdt_reset
);
   generate
      if (CNT_W < 8 || CNT_W > BUS_W) begin : g_bad_cnt
         $error("CNT_W must lie between 8 and the bus width");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("RST_CYCLES must be at least 1");
      end
   endgenerate

   logic              wr_ctrl, wr_load, wr_trig, wr_seq;
   logic              bz_ctrl, bz_load, bz_trig, bz_seq;
   logic              st_ctrl, st_load, st_trig, st_seq;
   logic [CTRL_W-1:0] sh_ctrl;
   logic [CNT_W-1:0]  sh_load, sh_trig, f_count, b_count;
   logic [KEY_W-1:0]  sh_seq;
   logic              sys_bit;
   logic [BUS_W-1:0]  pend_word;

   assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
   assign wr_load = bus_wr && (bus_addr == RA_LOAD);
   assign wr_trig = bus_wr && (bus_addr == RA_TRIG);
   assign wr_seq  = bus_wr && (bus_addr == RA_SEQ);

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n)                             sys_bit <= 1'b0;
      else if (bus_wr && bus_addr == RA_SYS)  sys_bit <= bus_wdata[0];
   end

   wdu_posted_reg #(.W(CTRL_W)) u_ctrl (
      .bclk(bclk), .fclk(fclk), .rst_n(rst_n), .wr_hit(wr_ctrl),
      .wdata(bus_wdata[CB_PEN:CB_PTV_L]), .busy(bz_ctrl),
      .shadow(sh_ctrl), .f_stb(st_ctrl));

   wdu_posted_reg #(.W(CNT_W)) u_load (
      .bclk(bclk), .fclk(fclk), .rst_n(rst_n), .wr_hit(wr_load),
      .wdata(bus_wdata[CNT_W-1:0]), .busy(bz_load),
      .shadow(sh_load), .f_stb(st_load));

   wdu_posted_reg #(.W(CNT_W)) u_trig (
      .bclk(bclk), .fclk(fclk), .rst_n(rst_n), .wr_hit(wr_trig),
      .wdata(bus_wdata[CNT_W-1:0]), .busy(bz_trig),
      .shadow(sh_trig), .f_stb(st_trig));

   wdu_posted_reg #(.W(KEY_W)) u_seq (
      .bclk(bclk), .fclk(fclk), .rst_n(rst_n), .wr_hit(wr_seq),
      .wdata(bus_wdata[KEY_W-1:0]), .busy(bz_seq),
      .shadow(sh_seq), .f_stb(st_seq));

   wdu_core #(
      .CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES), .HAS_PRESCALER(HAS_PRESCALER)
   ) u_core (
      .fclk(fclk), .rst_n(rst_n),
      .ctrl_stb(st_ctrl), .ctrl_val(sh_ctrl),
      .load_stb(st_load), .load_val(sh_load),
      .trig_stb(st_trig), .trig_val(sh_trig),
      .seq_stb(st_seq),   .seq_val(sh_seq),
      .count_o(f_count),  .wdt_reset_o(wdt_reset));

   wdu_snap #(.W(CNT_W)) u_snap (
      .bclk(bclk), .fclk(fclk), .rst_n(rst_n),
      .f_val(f_count), .b_val(b_count));

   always_comb begin
      pend_word          = '0;
      pend_word[PB_CTRL] = bz_ctrl;
      pend_word[PB_LOAD] = bz_load;
      pend_word[PB_TRIG] = bz_trig;
      pend_word[PB_SEQ]  = bz_seq;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_REV:   bus_rdata[7:0] = REV_CODE;
         RA_SYS:   bus_rdata[0] = sys_bit;
         RA_CTRL:  bus_rdata[CB_PEN:CB_PTV_L] = sh_ctrl;
         RA_COUNT: bus_rdata[CNT_W-1:0] = b_count;
         RA_LOAD:  bus_rdata[CNT_W-1:0] = sh_load;
         RA_TRIG:  bus_rdata[CNT_W-1:0] = sh_trig;
         RA_PEND:  bus_rdata = pend_word;
         RA_SEQ:   bus_rdata[KEY_W-1:0] = sh_seq;
         default:  bus_rdata = '0;
      endcase
   end

   assert_pend_idle_R1: assert property (@(posedge bclk) disable iff (!rst_n)
      (!bus_wr && pend_word == '0) |=> (pend_word == '0));

endmodule

// File: tb/sim_wdt_unlock.sv
module sim_wdt_unlock;
   localparam int CLK_PERIOD = 10;
   localparam int F_PERIOD   = 34;
   localparam int RSTC       = 6;
   localparam logic [7:0] REV = 8'h5A;

   logic        bclk = 1'b0, fclk = 1'b0, rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        wdt_reset;

   int checks = 0, fails = 0;

   always #(CLK_PERIOD/2) bclk = ~bclk;
   always #(F_PERIOD/2)   fclk = ~fclk;

   wdt_unlock #(.RST_CYCLES(RSTC), .REV_CODE(REV)) u0 (
      .bclk(bclk), .fclk(fclk), .rst_n(rst_n), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wdt_reset(wdt_reset));

   typedef struct packed {
      logic [2:0]  a;
      logic [31:0] d;
      logic [31:0] e;
   } vec_t;

   // register write / readback table (R10, R8 readback mask)
   localparam vec_t VEC [6] = '{
      '{3'd1, 32'h0000_0001, 32'h0000_0001},
      '{3'd1, 32'hFFFF_FFFE, 32'h0000_0000},
      '{3'd2, 32'h0000_00FF, 32'h0000_003C},
      '{3'd2, 32'h0000_0000, 32'h0000_0000},
      '{3'd0, 32'h0000_0000, 32'h0000_005A},
      '{3'd4, 32'h0000_0100, 32'h0000_0100}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge bclk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge bclk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge bclk);
   endtask

   task automatic wait_clear();
      logic [31:0] p;
      for (int i = 0; i < 200; i++) begin
         rd(3'd6, p);
         if (p == 32'd0) break;
         @(negedge bclk);
      end
   endtask

   task automatic wr_post(input logic [2:0] a, input logic [31:0] d);
      wr(a, d);
      wait_clear();
   endtask

   task automatic measure(output int period, output int width);
      period = 0; width = 0;
      do @(negedge fclk); while (wdt_reset);
      do @(negedge fclk); while (!wdt_reset);
      while (wdt_reset)  begin width++; period++; @(negedge fclk); end
      while (!wdt_reset) begin period++; @(negedge fclk); end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] v, c1, c2;
      int per, wid;
      idle(5);
      rst_n = 1'b1;
      idle(40);

      // R1 reset state
      rd(3'd6, v); check("R1 pending", v, 32'd0);
      rd(3'd4, v); check("R1 load", v, 32'd0);
      rd(3'd3, v); check("R1 counter", v, 32'd0);
      check("R1 wdt_reset", {31'd0, wdt_reset}, 32'd0);

      // table walk
      foreach (VEC[i]) begin
         wr_post(VEC[i].a, VEC[i].d);
         rd(VEC[i].a, v);
         check("R10 table", v, VEC[i].e);
      end

      // R5 pending bit positions
      wr(3'd4, 32'h100); rd(3'd6, v); check("R5 load pend", v, 32'h04);
      wait_clear(); rd(3'd6, v); check("R5 load clear", v, 32'd0);
      wr(3'd2, 32'h0);   rd(3'd6, v); check("R5 ctrl pend", v, 32'h01);
      wait_clear();
      wr(3'd5, 32'h1234); rd(3'd6, v); check("R5 trig pend", v, 32'h08);
      wait_clear();
      wr(3'd7, 32'h1111); rd(3'd6, v); check("R5 seq pend", v, 32'h10);
      wait_clear(); rd(3'd6, v); check("R5 all clear", v, 32'd0);
      idle(40);
      rd(3'd3, v); check("R7 first reload", v, 32'h100);

      // R6 second write while pending is dropped
      wr(3'd4, 32'h300);
      wr(3'd4, 32'h400);
      wait_clear();
      rd(3'd4, v); check("R6 load readback", v, 32'h300);
      wr_post(3'd5, 32'hEDCB); idle(40);
      rd(3'd3, v); check("R6 far side value", v, 32'h300);

      // R7 same trigger value does not reload
      wr_post(3'd4, 32'h500);
      wr_post(3'd5, 32'hEDCB); idle(40);
      rd(3'd3, v); check("R7 same trigger", v, 32'h300);
      wr_post(3'd5, 32'h1234); idle(40);
      rd(3'd3, v); check("R7 new trigger", v, 32'h500);

      // R3 wrong orderings keep it stopped
      wr_post(3'd7, 32'h4444);
      wr_post(3'd7, 32'hBBBB);
      idle(60); rd(3'd3, v); check("R3 reversed keys", v, 32'h500);
      wr_post(3'd7, 32'h2222);
      wr_post(3'd7, 32'h4444);
      idle(60); rd(3'd3, v); check("R3 interrupted keys", v, 32'h500);

      // R2 correct start
      wr_post(3'd7, 32'hBBBB);
      wr_post(3'd7, 32'h4444);
      idle(40); rd(3'd3, c1);
      idle(40); rd(3'd3, c2);
      check("R2 counter advances", {31'd0, (c2 > c1) && (c1 > 32'h500)}, 32'd1);

      // R4 stop
      wr_post(3'd7, 32'hAAAA);
      wr_post(3'd7, 32'h5555);
      idle(40); rd(3'd3, c1);
      idle(60); rd(3'd3, c2);
      check("R4 counter holds", c2, c1);

      // R9 wrap period and pulse width, no prescaler
      wr_post(3'd4, 32'hFFFF_FFF8);
      wr_post(3'd5, 32'h0F0F);
      wr_post(3'd7, 32'hBBBB);
      wr_post(3'd7, 32'h4444);
      measure(per, wid);
      check("R9 period", per, 32'd8);
      check("R9 width", wid, RSTC);

      // R8 prescaler P=2
      wr_post(3'd2, 32'h28);
      measure(per, wid);
      measure(per, wid);
      check("R8 prescaled period", per, 32'd32);
      check("R9 width prescaled", wid, RSTC);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule